// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is a byte-wide synchronous serial port that runs either as an SPI master, generating the serial clock itself, or as an SPI slave, following a clock driven from outside. One control register holds an enable bit, a clock-polarity bit, a 4-bit mode field and two sticky status flags. A single data buffer sits in front of an internal shift register. A buffer write loads the byte to be sent straight into the shift register, and in master mode that write also starts the transfer. A buffer read returns the last byte received.

The master can take its serial clock from the system clock divided by 4, 16 or 64, or from an external timer tick divided by two. In slave mode the serial clock, data input and slave select are first synchronized into the system clock domain. One slave mode uses slave select to frame bytes. The other ignores it. Two flags record misuse: a buffer write while a byte is still shifting, and a received byte that arrives while the buffer still holds an unread one.

Top module: `spi_port`

## Requirements
- R1: After reset every control field and both flags read 0, `buf_full` is 0 and neither `sck_oe` nor `sdo_oe` is asserted. The control read layout is: bit 0 enable, bit 1 polarity, bits 5:2 mode, bit 6 write-collision flag, bit 7 overflow flag.
- R2: While enable is 0, `sck_oe` and `sdo_oe` are 0, and a buffer write starts no transfer: no clock edge is produced and `buf_full` stays 0. In a master mode with enable 1, `sck_oe` is 1.
- R3: Between transfers the master serial clock rests at the polarity bit: high when it is 1, low when it is 0.
- R4: Modes 0x0, 0x1 and 0x2 are master modes whose serial clock half-period is 2, 8 and 32 system clocks. Mode 0x3 is a master mode that produces one serial clock edge per timer tick. A byte takes 16 edges.
- R5: Bytes are 8 bits and are shifted most significant bit first. Input is sampled on the edge that leaves the idle level, and output changes on the edge that returns to it. When a received byte is loaded into the buffer, `buf_full` is set. A buffer read clears it.
- R6: A buffer write while a byte is shifting sets bit 6, and the written data is discarded. Bit 6 is cleared only by a control write with bit 6 at 0. A control write with bit 6 at 1 leaves it unchanged.
- R7: In a slave mode, a byte that completes while `buf_full` is 1 sets bit 7, and that byte is discarded, so the buffer keeps the earlier one. Bit 7 is cleared only by a control write with bit 7 at 0.
- R8: In master modes bit 7 is never set. Each completed byte overwrites the buffer.
- R9: Mode 0x4 is a slave mode in which a high `ss_n_i` tri-states data out and clears the bit counter, so a partly received byte is dropped. Mode 0x5 is a slave mode that ignores `ss_n_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (bit 6 and bit 7 at 0 clear the flags) |
| ctl_rdata | output | 8 | Control register and flag readback |
| buf_we | input | 1 | Data buffer write strobe |
| buf_wdata | input | 8 | Byte to transmit |
| buf_re | input | 1 | Data buffer read strobe, clears `buf_full` |
| buf_rdata | output | 8 | Last received byte |
| buf_full | output | 1 | Received byte waiting to be read |
| tmr_tick | input | 1 | Timer tick for master mode 0x3 |
| sck_i | input | 1 | Serial clock from the bus (slave) |
| sck_o | output | 1 | Serial clock driven (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| ss_n_i | input | 1 | Slave select, active low |

## Verification
In master mode, the received byte and `buf_full` show up two system clocks after the final clock edge that returns to idle. The bench waits four cycles after counting the sixteenth edge before it samples them. Flags and `sck_oe`/`sdo_oe` change one cycle after the write or mode change that causes them. Slave inputs pass through a two-flop synchronizer and an edge register, so every slave response arrives three to four cycles after the bus event. The bench therefore holds each slave clock level for six cycles, reads data out just before it drives a leading edge, and waits ten cycles after the last edge before it checks the buffer and flags. The master's edge timing is checked by counting system clocks between the first and sixteenth serial clock edge, so the check does not depend on the start-up latency.

// File: rtl/spi_port_pkg.sv
// Shared types and constants for the SPI master/slave port.
// Assumes an 8-bit byte; the control layout below is the software view.
package spi_port_pkg;

    localparam int BYTE_W = 8;

    // Mode field encodings
    localparam logic [3:0] MD_MST_DA  = 4'h0;
    localparam logic [3:0] MD_MST_DB  = 4'h1;
    localparam logic [3:0] MD_MST_DC  = 4'h2;
    localparam logic [3:0] MD_MST_TMR = 4'h3;
    localparam logic [3:0] MD_SLV_SEL = 4'h4;
    localparam logic [3:0] MD_SLV_FREE = 4'h5;

    // Control/status register as read back, MSB first
    typedef struct packed {
        logic       ovf;
        logic       wcol;
        logic [3:0] mode;
        logic       cpol;
        logic       en;
    } ctl_t;

endpackage

// File: rtl/spi_sync.sv
// Two-flop synchronizer for a group of asynchronous inputs.
// Assumes each input is stable for at least two clk periods per level.
module spi_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic s1, s2;
            // Capture one input bit through two flops
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= 1'b0;
                    s2 <= 1'b0;
                end else begin
                    s1 <= din[g];
                    s2 <= s1;
                end
            end
            assign dout[g] = s2;
        end
    endgenerate

endmodule

// File: rtl/spi_mclk.sv
// Master serial clock edge generator. Emits a one-cycle tick at every
// serial clock edge while run is high. Selections 0..2 divide the system
// clock by DIV_A/DIV_B/DIV_C; selection 3 passes the timer tick through,
// giving one edge per tick (a full period every two ticks).
// Assumes DIV_C is the largest divider and all dividers are even and >= 4.
module spi_mclk #(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int DIV_C = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    input  logic       tmr_tick,
    output logic       tick
);

    localparam int CW = $clog2(DIV_C / 2);

    logic [CW-1:0] cnt;
    logic [CW-1:0] half_m1;

    // Pick the half-period terminal count
    always_comb begin
        case (sel)
            2'd0:    half_m1 = CW'(DIV_A / 2 - 1);
            2'd1:    half_m1 = CW'(DIV_B / 2 - 1);
            default: half_m1 = CW'(DIV_C / 2 - 1);
        endcase
    end

    // Half-period counter, held at zero while idle or on the timer source
    always_ff @(posedge clk) begin
        if (!rst_n || !run || sel == 2'd3) begin
            cnt <= '0;
        end else if (cnt == half_m1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && ((sel == 2'd3) ? tmr_tick : (cnt == half_m1));

endmodule

// File: rtl/spi_shift.sv
// Shift engine shared by master and slave. lead samples sdi; trail shifts
// the sample in MSB-first and presents the next output bit. done pulses
// the cycle after the last trailing edge, with rx_data valid then.
// Assumes lead/trail are single-cycle strobes; clr has priority over edges.
module spi_shift #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [BW-1:0] load_data,
    input  logic          lead,
    input  logic          trail,
    input  logic          sdi,
    output logic          sdo,
    output logic          done,
    output logic          last,
    output logic          active,
    output logic          phase,
    output logic [BW-1:0] rx_data
);

    localparam int CW = $clog2(BW);

    logic [BW-1:0] shreg;
    logic [CW-1:0] cnt;
    logic          phase_q;
    logic          samp;
    logic          done_q;

    // Bit counter, phase, sample and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            cnt     <= '0;
            phase_q <= 1'b0;
            samp    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                shreg <= load_data;
            end
            if (clr) begin
                cnt     <= '0;
                phase_q <= 1'b0;
            end else if (!load && lead && !phase_q) begin
                phase_q <= 1'b1;
                samp    <= sdi;
            end else if (!load && trail && phase_q) begin
                phase_q <= 1'b0;
                shreg   <= {shreg[BW-2:0], samp};
                if (cnt == CW'(BW - 1)) begin
                    cnt    <= '0;
                    done_q <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign sdo     = shreg[BW-1];
    assign done    = done_q;
    assign last    = (cnt == CW'(BW - 1));
    assign active  = (cnt != '0) || phase_q;
    assign phase   = phase_q;
    assign rx_data = shreg;

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !active); // R9

endmodule

// File: rtl/spi_port.sv
// Configurable SPI master/slave port with one data buffer and sticky
// write-collision and receive-overflow flags. A buffer write loads the
// shift register directly (and starts a master transfer); a buffer read
// returns the last byte accepted. Assumes slave-side bus signals are slow
// enough to survive a two-flop synchronizer (>= 3 clk per level).
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int DIV_C = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [7:0]  ctl_wdata,
    output logic [7:0]  ctl_rdata,
    input  logic        buf_we,
    input  logic [7:0]  buf_wdata,
    input  logic        buf_re,
    output logic [7:0]  buf_rdata,
    output logic        buf_full,
    input  logic        tmr_tick,
    input  logic        sck_i,
    output logic        sck_o,
    output logic        sck_oe,
    input  logic        sdi_i,
    output logic        sdo_o,
    output logic        sdo_oe,
    input  logic        ss_n_i
);

    localparam int BW = BYTE_W;

    ctl_t          ctl_q;
    ctl_t          ctl_w;
    logic [BW-1:0] rxbuf;
    logic          full_q;
    logic          mbusy;

    logic          is_master, is_slave, ss_mode;
    logic          busy_any, wr_ok, clr;
    logic          mtick, lead, trail, sdi_sel;
    logic          sh_sdo, sh_done, sh_last, sh_active, sh_phase;
    logic [BW-1:0] sh_rx;

    logic [2:0]    sync_out;
    logic          sck_s, sdi_s, ss_s, sck_d;
    logic          s_edge, s_lead, s_trail;

    assign ctl_w = ctl_t'(ctl_wdata);

    // Mode decode
    always_comb begin
        is_master = ctl_q.en && (ctl_q.mode[3:2] == 2'b00);
        is_slave  = ctl_q.en && (ctl_q.mode == MD_SLV_SEL || ctl_q.mode == MD_SLV_FREE);
        ss_mode   = (ctl_q.mode == MD_SLV_SEL);
    end

    // Slave-side input synchronizer
    spi_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ss_n_i, sdi_i, sck_i}),
        .dout  (sync_out)
    );
    assign sck_s = sync_out[0];
    assign sdi_s = sync_out[1];
    assign ss_s  = sync_out[2];

    // Previous synchronized clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign s_edge  = sck_s ^ sck_d;
    assign s_lead  = is_slave && s_edge && (sck_s != ctl_q.cpol);
    assign s_trail = is_slave && s_edge && (sck_s == ctl_q.cpol);

    // Master edge generator
    spi_mclk #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_mclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (mbusy),
        .sel      (ctl_q.mode[1:0]),
        .tmr_tick (tmr_tick),
        .tick     (mtick)
    );

    // Edge and data routing between master and slave paths
    always_comb begin
        if (is_master) begin
            lead    = mtick && !sh_phase;
            trail   = mtick && sh_phase;
            sdi_sel = sdi_i;
        end else begin
            lead    = s_lead;
            trail   = s_trail;
            sdi_sel = sdi_s;
        end
    end

    assign busy_any = is_master ? mbusy : sh_active;
    assign wr_ok    = buf_we && !busy_any;
    assign clr      = !ctl_q.en || (is_slave && ss_mode && ss_s);

    spi_shift #(.BW(BW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .load      (wr_ok),
        .load_data (buf_wdata),
        .lead      (lead),
        .trail     (trail),
        .sdi       (sdi_sel),
        .sdo       (sh_sdo),
        .done      (sh_done),
        .last      (sh_last),
        .active    (sh_active),
        .phase     (sh_phase),
        .rx_data   (sh_rx)
    );

    // Master transfer in progress: set by an accepted write, cleared on last trailing edge
    always_ff @(posedge clk) begin
        if (!rst_n || !is_master) begin
            mbusy <= 1'b0;
        end else if (wr_ok) begin
            mbusy <= 1'b1;
        end else if (trail && sh_last) begin
            mbusy <= 1'b0;
        end
    end

    // Control fields and sticky flags; hardware set wins over software clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            if (ctl_we) begin
                ctl_q.en   <= ctl_w.en;
                ctl_q.cpol <= ctl_w.cpol;
                ctl_q.mode <= ctl_w.mode;
            end
            if (buf_we && busy_any) begin
                ctl_q.wcol <= 1'b1;
            end else if (ctl_we && !ctl_w.wcol) begin
                ctl_q.wcol <= 1'b0;
            end
            if (sh_done && is_slave && full_q) begin
                ctl_q.ovf <= 1'b1;
            end else if (ctl_we && !ctl_w.ovf) begin
                ctl_q.ovf <= 1'b0;
            end
        end
    end

    // Receive buffer and full status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxbuf  <= '0;
            full_q <= 1'b0;
        end else if (sh_done && (is_master || !full_q)) begin
            rxbuf  <= sh_rx;
            full_q <= 1'b1;
        end else if (buf_re) begin
            full_q <= 1'b0;
        end
    end

    assign ctl_rdata = ctl_q;
    assign buf_rdata = rxbuf;
    assign buf_full  = full_q;
    assign sck_o     = ctl_q.cpol ^ (is_master && sh_phase);
    assign sck_oe    = is_master;
    assign sdo_o     = sh_sdo;
    assign sdo_oe    = is_master || (is_slave && !(ss_mode && ss_s));

    AST_MASTER_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !ctl_q.ovf && !ctl_we) |=> !ctl_q.ovf); // R8
    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !mbusy) |-> (sck_o == ctl_q.cpol)); // R3
    AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.wcol && !ctl_we) |=> ctl_q.wcol); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ovf && !ctl_we) |=> ctl_q.ovf); // R7
    AST_PINS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.en |-> (!sck_oe && !sdo_oe)); // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_re && !sh_done) |=> !buf_full); // R5

endmodule

// File: tb/spi_port_tb.sv
module spi_port_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctl_we;
    logic [7:0] ctl_wdata;
    logic [7:0] ctl_rdata;
    logic       buf_we;
    logic [7:0] buf_wdata;
    logic       buf_re;
    logic [7:0] buf_rdata;
    logic       buf_full;
    logic       tmr_tick;
    logic       sck_i;
    logic       sck_o;
    logic       sck_oe;
    logic       sdi_i;
    logic       sdo_o;
    logic       sdo_oe;
    logic       ss_n_i;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    spi_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_re(buf_re),
        .buf_rdata(buf_rdata), .buf_full(buf_full),
        .tmr_tick(tmr_tick),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
        .ss_n_i(ss_n_i)
    );

    // {mode[3:0], cpol, 3'b0, tx[7:0], rx[7:0]}
    localparam logic [23:0] VEC [6] = '{
        {4'h0, 1'b1, 3'b0, 8'hA5, 8'h3C},
        {4'h1, 1'b0, 3'b0, 8'h81, 8'h7E},
        {4'h2, 1'b1, 3'b0, 8'h00, 8'hFF},
        {4'h3, 1'b0, 3'b0, 8'h5A, 8'hC3},
        {4'h0, 1'b0, 3'b0, 8'hFF, 8'h00},
        {4'h3, 1'b1, 3'b0, 8'h96, 8'h69}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [7:0] d);
        ctl_wdata = d; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic buf_write(input logic [7:0] d);
        buf_wdata = d; buf_we = 1'b1;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic buf_read();
        buf_re = 1'b1;
        @(negedge clk);
        buf_re = 1'b0;
    endtask

    function automatic int half_of(input logic [3:0] md);
        case (md)
            4'h0:    return 2;
            4'h1:    return 8;
            4'h2:    return 32;
            default: return 4;   // timer tick every 4 clocks
        endcase
    endfunction

    // Acts as the far-end slave for a master transfer
    task automatic do_master(input logic [3:0] md, input logic cp,
                             input logic [7:0] tx, input logic [7:0] rx,
                             input int wr_at, output logic [7:0] cap,
                             output int edges, output int span);
        int first_t, last_t, bidx;
        logic prev;
        ctl_write({2'b11, md, cp, 1'b1});
        sdi_i = rx[7];
        cap = '0; edges = 0; bidx = 0; first_t = 0; last_t = 0;
        buf_write(tx);
        prev = sck_o;
        for (int c = 0; c < 4000 && edges < 16; c++) begin
            tmr_tick = (c % 4 == 0);
            if (c == wr_at) begin buf_wdata = 8'h00; buf_we = 1'b1; end
            @(negedge clk);
            buf_we = 1'b0;
            if (sck_o != prev) begin
                if (edges == 0) first_t = c;
                last_t = c;
                edges++;
                if (sck_o != cp) cap = {cap[6:0], sdo_o};
                else begin
                    bidx++;
                    if (bidx < 8) sdi_i = rx[7 - bidx];
                end
                prev = sck_o;
            end
        end
        tmr_tick = 1'b0;
        repeat (4) @(negedge clk);
        span = last_t - first_t;
    endtask

    // Acts as the bus master for a slave transfer (6 clocks per level)
    task automatic do_slave(input logic cp, input logic [7:0] mtx,
                            input int nbits, output logic [7:0] cap);
        cap = '0;
        for (int i = 0; i < nbits; i++) begin
            sdi_i = mtx[7 - i];
            repeat (6) @(negedge clk);
            cap = {cap[6:0], sdo_o};
            sck_i = ~cp;
            repeat (6) @(negedge clk);
            sck_i = cp;
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog (all R): actual hang expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] cap;
        int edges, span;
        rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; buf_we = 1'b0; buf_wdata = '0;
        buf_re = 1'b0; tmr_tick = 1'b0; sck_i = 1'b0; sdi_i = 1'b0; ss_n_i = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(ctl_rdata == 8'h00, "R1", "ctl after reset", ctl_rdata, 0);
        check(buf_full == 1'b0, "R1", "buf_full after reset", buf_full, 0);
        check(!sck_oe && !sdo_oe, "R1", "pins after reset", {sck_oe, sdo_oe}, 0);

        // Vector walk: master transfers (R2 R3 R4 R5)
        for (int v = 0; v < 6; v++) begin
            logic [3:0] md;
            logic cp;
            logic [7:0] tx, rx;
            md = VEC[v][23:20]; cp = VEC[v][19]; tx = VEC[v][15:8]; rx = VEC[v][7:0];
            do_master(md, cp, tx, rx, -1, cap, edges, span);
            check(cap == tx, "R5", "master bits out MSB first", cap, tx);
            check(buf_rdata == rx, "R5", "master byte received", buf_rdata, rx);
            check(buf_full == 1'b1, "R5", "buf_full set", buf_full, 1);
            check(edges == 16, "R4", "edges per byte", edges, 16);
            check(span == 15 * half_of(md), "R4", "clock half period span", span, 15 * half_of(md));
            check(sck_o == cp, "R3", "idle clock level", sck_o, cp);
            check(sck_oe == 1'b1, "R2", "master drives clock", sck_oe, 1);
            buf_read();
            check(buf_full == 1'b0, "R5", "read clears buf_full", buf_full, 0);
        end

        // R6 write collision
        do_master(4'h1, 1'b0, 8'hC6, 8'h3A, 20, cap, edges, span);
        check(ctl_rdata[6] == 1'b1, "R6", "collision flag set", ctl_rdata[6], 1);
        check(cap == 8'hC6, "R6", "colliding write discarded", cap, 8'hC6);
        check(buf_rdata == 8'h3A, "R6", "rx unaffected", buf_rdata, 8'h3A);
        buf_read();
        ctl_write({2'b11, 4'h1, 1'b0, 1'b1});
        check(ctl_rdata[6] == 1'b1, "R6", "flag kept by writing 1", ctl_rdata[6], 1);
        ctl_write({2'b10, 4'h1, 1'b0, 1'b1});
        check(ctl_rdata[6] == 1'b0, "R6", "flag cleared by writing 0", ctl_rdata[6], 0);

        // R8 master never overflows
        do_master(4'h0, 1'b0, 8'h11, 8'h22, -1, cap, edges, span);
        do_master(4'h0, 1'b0, 8'h33, 8'h44, -1, cap, edges, span);
        check(ctl_rdata[7] == 1'b0, "R8", "no overflow in master", ctl_rdata[7], 0);
        check(buf_rdata == 8'h44, "R8", "buffer overwritten", buf_rdata, 8'h44);
        buf_read();

        // R7 slave overflow, mode 0x5 with slave select high (R9 ignored)
        sck_i = 1'b0; ss_n_i = 1'b1;
        ctl_write({2'b11, 4'h5, 1'b0, 1'b1});
        repeat (4) @(negedge clk);
        check(sdo_oe == 1'b1, "R9", "mode 5 ignores select", sdo_oe, 1);
        buf_write(8'hC3);
        do_slave(1'b0, 8'h5E, 8, cap);
        check(cap == 8'hC3, "R5", "slave bits out", cap, 8'hC3);
        check(buf_rdata == 8'h5E, "R5", "slave byte received", buf_rdata, 8'h5E);
        check(buf_full == 1'b1, "R5", "slave buf_full", buf_full, 1);
        check(ctl_rdata[7] == 1'b0, "R7", "no overflow yet", ctl_rdata[7], 0);
        buf_write(8'h0F);
        do_slave(1'b0, 8'h11, 8, cap);
        check(ctl_rdata[7] == 1'b1, "R7", "overflow set", ctl_rdata[7], 1);
        check(buf_rdata == 8'h5E, "R7", "new byte discarded", buf_rdata, 8'h5E);
        ctl_write({2'b11, 4'h5, 1'b0, 1'b1});
        check(ctl_rdata[7] == 1'b1, "R7", "overflow kept by writing 1", ctl_rdata[7], 1);
        ctl_write({2'b01, 4'h5, 1'b0, 1'b1});
        check(ctl_rdata[7] == 1'b0, "R7", "overflow cleared by writing 0", ctl_rdata[7], 0);
        buf_read();

        // R9 slave select mode 0x4, clock idles high
        sck_i = 1'b1; ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
        ctl_write({2'b11, 4'h4, 1'b1, 1'b1});
        repeat (5) @(negedge clk);
        check(sdo_oe == 1'b0, "R9", "deselected data out released", sdo_oe, 0);
        ss_n_i = 1'b0;
        repeat (5) @(negedge clk);
        check(sdo_oe == 1'b1, "R9", "selected data out driven", sdo_oe, 1);
        buf_write(8'hAA);
        do_slave(1'b1, 8'hFF, 3, cap);
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
        check(sdo_oe == 1'b0, "R9", "deselect mid byte releases", sdo_oe, 0);
        ss_n_i = 1'b0;
        repeat (5) @(negedge clk);
        buf_write(8'hA7);
        check(ctl_rdata[6] == 1'b0, "R9", "counter reset, no collision", ctl_rdata[6], 0);
        do_slave(1'b1, 8'h3B, 8, cap);
        check(cap == 8'hA7, "R9", "full byte out after reselect", cap, 8'hA7);
        check(buf_rdata == 8'h3B, "R9", "partial byte dropped", buf_rdata, 8'h3B);
        buf_read();

        // R2 disabled port
        ctl_write({2'b11, 4'h0, 1'b0, 1'b0});
        buf_write(8'h55);
        repeat (40) @(negedge clk);
        check(!sck_oe && !sdo_oe, "R2", "disabled pins released", {sck_oe, sdo_oe}, 0);
        check(sck_o == 1'b0, "R2", "no clock edges while disabled", sck_o, 0);
        check(buf_full == 1'b0, "R2", "no transfer while disabled", buf_full, 0);

        summary();
        $finish;
    end

endmodule